// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that lives in a word-addressed memory. A request carries the virtual address and a flag that says whether the access is a write. On acceptance the walker samples the base frame of the outer table from a dedicated input. It then reads the outer entry, which names the frame that holds the inner table. Next it reads the inner entry, which names the data frame. It returns either the physical address or a fault code on a response channel.

The virtual address is split, from the top down, into a 10-bit outer index, a 10-bit inner index and a 12-bit byte offset into a 4 KB page. Each entry is one 32-bit word. A table of 1024 entries therefore fills exactly one page, and a table's word address is its frame number followed by the index. The memory port accepts one read at a time through a valid/ready handshake and answers after a variable delay. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: The first memory read goes to word address {base frame, vaddr[31:22]}, using the base frame sampled in the cycle the request is accepted; later changes on the base input, address or write flag do not affect the walk.
- R2: When the outer entry is valid, the second memory read goes to word address {outer entry[31:12], vaddr[21:12]}.
- R3: An entry word holds the valid flag in bit 0 (1 = valid), the read-only flag in bit 1 (1 = read-only) and the frame number in bits 31:12; bits 11:2 are ignored. A successful walk returns status 2'b00 and physical address {inner entry[31:12], vaddr[11:0]}.
- R4: If the outer entry is invalid, the walk ends after exactly one memory read with status 2'b01 (invalid page), whatever the write flag or read-only bit.
- R5: If the inner entry is invalid, the response is status 2'b01 even when the access is a write and a read-only flag is set.
- R6: A write whose outer or inner entry (both valid) carries the read-only flag returns status 2'b10 (protection violation); a read through the same entries succeeds.
- R7: A memory read request keeps its valid and address stable until accepted, and its address stays unchanged until the read data returns; no new read is issued while one is pending.
- R8: A request is accepted only while no walk is in progress; the response stays valid with stable address and status until taken, and the walker is free again in the cycle after it is taken.
- R9: After reset the walker is ready for a request and drives no memory read and no response.
- R10: Every fault response carries physical address zero, and status 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| ptbase | input | 20 | Frame number of the outer table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 30 | Word address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_status | output | 2 | 00 ok, 01 invalid page, 10 protection violation |

## Verification
The invalid-page check and the write-protection check can both apply to the same walk. This happens when a write reaches an entry that is at once invalid and marked read-only, or when a read-only outer entry leads to an invalid inner entry. Directed walks build exactly these overlapping entries, and each walk is judged on the returned status and on the number of memory reads the walker made. Random walks over hashed table contents, with random memory stalls and latencies, also produce such overlaps, and a bench model that applies the invalid-first priority judges them.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20,
  localparam int VA_W = 2 * IDX_W + OFF_W,
  localparam int PA_W = PFN_W + OFF_W,
  localparam int MA_W = PFN_W + IDX_W,
  localparam int ENT_W = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic [PFN_W-1:0] ptbase,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [MA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_status
);
  localparam logic [1:0] ST_OK = 2'b00, ST_INV = 2'b01, ST_PROT = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_OREQ, S_OWAIT, S_IREQ, S_IWAIT, S_RESP} state_t;
  state_t state;

  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic            ro_q;
  logic [MA_W-1:0] addr_q;
  logic [PA_W-1:0] pa_q;
  logic [1:0]      stat_q;

  wire             ent_valid = mem_rsp_data[0];
  wire             ent_ro    = mem_rsp_data[1];
  wire [PFN_W-1:0] ent_pfn   = mem_rsp_data[ENT_W-1 -: PFN_W];
  wire             unused_rsvd = ^mem_rsp_data[OFF_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      va_q   <= '0;
      wr_q   <= 1'b0;
      ro_q   <= 1'b0;
      addr_q <= '0;
      pa_q   <= '0;
      stat_q <= ST_OK;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          addr_q <= {ptbase, req_vaddr[VA_W-1 -: IDX_W]};
          state  <= S_OREQ;
        end
        S_OREQ: if (mem_req_ready) state <= S_OWAIT;
        S_OWAIT: if (mem_rsp_valid) begin
          if (!ent_valid) begin
            stat_q <= ST_INV;
            pa_q   <= '0;
            state  <= S_RESP;
          end else begin
            ro_q   <= ent_ro;
            addr_q <= {ent_pfn, va_q[OFF_W +: IDX_W]};
            state  <= S_IREQ;
          end
        end
        S_IREQ: if (mem_req_ready) state <= S_IWAIT;
        S_IWAIT: if (mem_rsp_valid) begin
          state <= S_RESP;
          if (!ent_valid) begin
            stat_q <= ST_INV;
            pa_q   <= '0;
          end else if (wr_q && (ro_q || ent_ro)) begin
            stat_q <= ST_PROT;
            pa_q   <= '0;
          end else begin
            stat_q <= ST_OK;
            pa_q   <= {ent_pfn, va_q[OFF_W-1:0]};
          end
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_OREQ) || (state == S_IREQ);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state == S_RESP);
  assign rsp_paddr     = pa_q;
  assign rsp_status    = stat_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20,
  localparam int VA_W = 2 * IDX_W + OFF_W,
  localparam int PA_W = PFN_W + OFF_W,
  localparam int MA_W = PFN_W + IDX_W,
  localparam int ENT_W = PFN_W + OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             req_write,
  input logic [PFN_W-1:0] ptbase,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [MA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [ENT_W-1:0] mem_rsp_data,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_status
);
  logic pending;
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pending <= 1'b1;
    else if (mem_rsp_valid) pending <= 1'b0;
  end

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7
  mem_wait_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !mem_rsp_valid |=> $stable(mem_req_addr));

  // R7
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_req_valid);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_status));

  // R8
  idle_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid && !pending);

  // R10
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 2'b00 |-> rsp_paddr == '0 && rsp_status != 2'b11);
endmodule

bind pt_walker pt_walker_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_chk (.*);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [19:0] ptbase = '0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        req_ready, mem_req_valid, rsp_valid;
  logic [29:0] mem_req_addr;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_status;

  pt_walker dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  int nrd = 0;
  logic [29:0] rd_addr [2];
  logic [31:0] ovr [logic [29:0]];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input logic [29:0] a);
    logic [31:0] h;
    if (ovr.exists(a)) return ovr[a];
    h = {2'b0, a} * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    h[0] = (h[3:2] != 2'b00);
    h[1] = (h[5:4] == 2'b00);
    return h;
  endfunction

  function automatic void model(input logic [19:0] base, input logic [31:0] va, input bit wr,
                                output logic [31:0] pa, output logic [1:0] st, output int nr,
                                output logic [29:0] a0, output logic [29:0] a1);
    logic [31:0] e0, e1;
    a0 = {base, va[31:22]};
    e0 = ent(a0);
    a1 = '0; nr = 1; pa = '0;
    if (!e0[0]) begin st = 2'b01; return; end
    a1 = {e0[31:12], va[21:12]};
    e1 = ent(a1);
    nr = 2;
    if (!e1[0]) st = 2'b01;
    else if (wr && (e0[1] || e1[1])) st = 2'b10;
    else begin st = 2'b00; pa = {e1[31:12], va[11:0]}; end
  endfunction

  // memory responder: random acceptance and latency
  initial begin
    bit busy = 0;
    int lat = 0;
    logic [29:0] cur = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (busy) begin
        mem_req_ready = 1'b0;
        if (lat == 0) begin
          chk(mem_req_addr == cur, "R7", "address held until data", {2'b0, mem_req_addr}, {2'b0, cur});
          mem_rsp_data = ent(cur);
          mem_rsp_valid = 1'b1;
          busy = 0;
        end else lat--;
      end else begin
        mem_req_ready = ($urandom % 3) != 0;
        if (mem_req_ready && mem_req_valid && rst_n) begin
          busy = 1;
          lat = $urandom % 4;
          cur = mem_req_addr;
          if (nrd < 2) rd_addr[nrd] = cur;
          nrd++;
        end
      end
    end
  end

  task automatic do_walk(input logic [19:0] base, input logic [31:0] va, input bit wr, input string tag);
    logic [31:0] epa; logic [1:0] est; int enr; logic [29:0] ea0, ea1;
    model(base, va, wr, epa, est, enr, ea0, ea1);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nrd = 0;
    ptbase = base; req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; ptbase = $urandom; req_vaddr = $urandom; req_write = ~wr;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_status == est, tag, "status", {30'b0, rsp_status}, {30'b0, est});
    chk(rsp_paddr == epa, "R3", "physical address", rsp_paddr, epa);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == epa && rsp_status == est, "R8", "held response",
          {rsp_valid, rsp_status, rsp_paddr[28:0]}, {1'b1, est, epa[28:0]});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R8", "free after take", {30'b0, req_ready, rsp_valid}, 32'h2);
    chk(nrd == enr, (enr == 1) ? "R4" : "R2", "memory reads", nrd, enr);
    chk(rd_addr[0] == ea0, "R1", "outer read address", {2'b0, rd_addr[0]}, {2'b0, ea0});
    if (enr == 2)
      chk(rd_addr[1] == ea1, "R2", "inner read address", {2'b0, rd_addr[1]}, {2'b0, ea1});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R9", "reset outputs",
        {29'b0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R9", "idle after reset",
        {29'b0, req_ready, mem_req_valid, rsp_valid}, 32'h4);

    // directed tables under base frame 0x00010
    ovr[{20'h00010, 10'd1}] = {20'h00020, 10'h3FF, 2'b11};   // outer valid, read-only
    ovr[{20'h00020, 10'd0}] = {20'hABCDE, 10'h000, 2'b10};   // inner invalid, read-only
    ovr[{20'h00020, 10'd1}] = {20'h12345, 10'h155, 2'b01};   // inner valid, writable
    ovr[{20'h00010, 10'd2}] = {20'hFFFFF, 10'h000, 2'b10};   // outer invalid, read-only
    ovr[{20'h00010, 10'd3}] = {20'h00030, 10'h000, 2'b01};   // outer valid, writable
    ovr[{20'h00030, 10'd5}] = {20'h0BEEF, 10'h2AA, 2'b11};   // inner valid, read-only
    ovr[{20'h00030, 10'd6}] = {20'h00777, 10'h000, 2'b01};   // inner valid, writable

    do_walk(20'h00010, 32'h0040_0ABC, 1'b1, "R5");   // inner invalid + read-only + write
    do_walk(20'h00010, 32'h0040_1123, 1'b1, "R6");   // outer read-only blocks write
    do_walk(20'h00010, 32'h0040_1123, 1'b0, "R6");   // same page, read is fine
    do_walk(20'h00010, 32'h0080_0FFF, 1'b1, "R4");   // outer invalid + read-only
    do_walk(20'h00010, 32'h0080_0000, 1'b0, "R4");
    do_walk(20'h00010, 32'h00C0_5FFF, 1'b1, "R6");   // inner read-only blocks write
    do_walk(20'h00010, 32'h00C0_5000, 1'b0, "R3");
    do_walk(20'h00010, 32'h00C0_6ABC, 1'b1, "R3");   // writable page, write ok
    do_walk(20'h00000, 32'h0000_0000, 1'b0, "R3");
    do_walk(20'hFFFFF, 32'hFFFF_FFFF, 1'b1, "R10");

    for (int i = 0; i < 400; i++)
      do_walk($urandom, $urandom, $urandom % 2, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule